// File: doc/BRIEF.md
# Power-Mode and Alarm Status LED Driver

This block drives a two-colour status indicator on a pluggable test module. The colour shows the power mode the host has selected. It shows green while the module sits in low power mode and red once the host has moved it to high power mode. The mode comes from a single host-facing pin. That pin has a pull-up inside the module, so a pin the host leaves undriven reads as low power mode. The pin level passes through a two-stage synchronizer before it is decoded.

A single alarm-present flag comes in from elsewhere on the module. While it is set, it takes precedence over the power-mode colour. The indicator then alternates between green and red, and each colour holds for a fixed number of clock cycles. A prescaler counter sets that count, and its default gives about 250 ms at a 125 MHz clock.

Two further host pins, the module-select level and the init-mode level, reach the block. Neither of them has any effect on the indicator. After reset the indicator stays dark until the synchronizer holds a real sample of the mode pin.

Top module: `status_led_drv`

## Requirements
- R1: While `rst` is high, and for the first two rising edges after `rst` falls, both `led_green` and `led_red` are 0. From the third edge onward, the LEDs reflect the mode pin as sampled two edges earlier.
- R2: `led_green` and `led_red` are never 1 in the same cycle.
- R3: With `alarm_any` at 0 and the host driving `lpm_level` to 1 (`lpm_drive` = 1), the indicator is solid green (`led_green` = 1, `led_red` = 0).
- R4: With `alarm_any` at 0 and the host driving `lpm_level` to 0, the indicator is solid red (`led_green` = 0, `led_red` = 1).
- R5: With `lpm_drive` at 0, the pin counts as pulled high whatever `lpm_level` carries, so the indicator is green when no alarm is set.
- R6: While `alarm_any` is 1, the indicator alternates, starting green on the first edge that samples the alarm. Each colour holds for exactly `HALF_CYCLES` edges, whatever the power mode is.
- R7: When `alarm_any` returns to 0, the solid power-mode colour comes back on the next edge. A later alarm restarts the blink from green with a full half-period.
- R8: The levels on `sel_pin_n` and `init_pin` have no effect on `led_green` or `led_red`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| lpm_drive | input | 1 | 1 when the host actively drives the mode pin; 0 means the pin floats and the internal pull-up wins |
| lpm_level | input | 1 | Level the host drives on the mode pin (1 = low power, 0 = high power) |
| alarm_any | input | 1 | 1 while any alarm flag is set |
| sel_pin_n | input | 1 | Module-select pin level, observed but unused |
| init_pin | input | 1 | Init-mode pin level, observed but unused |
| led_green | output | 1 | Green LED enable |
| led_red | output | 1 | Red LED enable |

## Verification
A wrong synchronizer or valid-stage value shows up as a wrong or missing colour. That happens exactly two edges after the mode pin changes, or within the first three edges after reset. A blink counter that has drifted, or a phase bit that was not cleared, shows as a colour flip that comes one or more edges early or late in the first half-period of an alarm. Every cycle's pair of LED enables is checked against an independent model, so each of these faults is caught on the first edge where it becomes visible.

// File: rtl/status_led_pkg.sv
package status_led_pkg;

    typedef enum logic {
        PWR_LOW  = 1'b0,
        PWR_HIGH = 1'b1
    } pwr_mode_e;

    typedef enum logic [1:0] {
        LED_DARK  = 2'b00,
        LED_GREEN = 2'b01,
        LED_RED   = 2'b10
    } led_colour_e;

    typedef struct packed {
        logic      valid;
        pwr_mode_e mode;
        logic      alarm;
        logic      phase_red;
    } led_status_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        int unsigned w;
        w = (n <= 1) ? 1 : $clog2(n);
        return (w == 0) ? 1 : w;
    endfunction

    function automatic led_colour_e pick_colour(input led_status_t s);
        led_colour_e c;
        if (!s.valid) begin
            c = LED_DARK;
        end else if (s.alarm) begin
            c = s.phase_red ? LED_RED : LED_GREEN;
        end else begin
            c = (s.mode == PWR_LOW) ? LED_GREEN : LED_RED;
        end
        return c;
    endfunction

endpackage

// File: rtl/lpm_pin_sync.sv
module lpm_pin_sync
    import status_led_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_level,
    output pwr_mode_e mode,
    output logic      sample_valid
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain;
    logic [LAST:0] valid_chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) begin
                        chain[0]       <= 1'b1;
                        valid_chain[0] <= 1'b0;
                    end else begin
                        chain[0]       <= pin_level;
                        valid_chain[0] <= 1'b1;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) begin
                        chain[i]       <= 1'b1;
                        valid_chain[i] <= 1'b0;
                    end else begin
                        chain[i]       <= chain[i-1];
                        valid_chain[i] <= valid_chain[i-1];
                    end
                end
            end
        end
    endgenerate

    assign mode         = chain[LAST] ? PWR_LOW : PWR_HIGH;
    assign sample_valid = valid_chain[LAST];
endmodule

// File: rtl/blink_timer.sv
module blink_timer
    import status_led_pkg::*;
#(
    parameter int unsigned HALF_CYCLES = 31_250_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic phase_red,
    output logic wrap
);
    localparam int unsigned CW = cnt_width(HALF_CYCLES);
    localparam logic [CW-1:0] TOP = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] count;

    assign wrap = run && (count == TOP);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            count     <= '0;
            phase_red <= 1'b0;
        end else if (wrap) begin
            count     <= '0;
            phase_red <= ~phase_red;
        end else begin
            count     <= count + 1'b1;
        end
    end
endmodule

// File: rtl/led_select.sv
module led_select
    import status_led_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  led_status_t status,
    output logic        green,
    output logic        red
);
    led_colour_e colour_d;
    led_colour_e colour_q;

    always_comb begin
        colour_d = pick_colour(status);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            colour_q <= LED_DARK;
        end else begin
            colour_q <= colour_d;
        end
    end

    assign green = (colour_q == LED_GREEN);
    assign red   = (colour_q == LED_RED);
endmodule

// File: rtl/status_led_drv.sv
module status_led_drv
    import status_led_pkg::*;
#(
    parameter int unsigned HALF_CYCLES = 31_250_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic lpm_drive,
    input  logic lpm_level,
    input  logic alarm_any,
    input  logic sel_pin_n,
    input  logic init_pin,
    output logic led_green,
    output logic led_red
);
    logic        pin_eff;
    pwr_mode_e   st_mode;
    logic        st_valid;
    logic        st_phase;
    logic        st_wrap;
    led_status_t status;
    logic        unused_pins;

    // Internal pull-up: an undriven pin resolves high (low power).
    assign pin_eff     = lpm_drive ? lpm_level : 1'b1;
    assign unused_pins = sel_pin_n ^ init_pin ^ st_wrap;

    lpm_pin_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk         (clk),
        .rst         (rst),
        .pin_level   (pin_eff),
        .mode        (st_mode),
        .sample_valid(st_valid)
    );

    blink_timer #(
        .HALF_CYCLES(HALF_CYCLES)
    ) u_blink (
        .clk      (clk),
        .rst      (rst),
        .run      (alarm_any),
        .phase_red(st_phase),
        .wrap     (st_wrap)
    );

    always_comb begin
        status.valid     = st_valid;
        status.mode      = st_mode;
        status.alarm     = alarm_any;
        status.phase_red = st_phase;
    end

    led_select u_sel (
        .clk   (clk),
        .rst   (rst),
        .status(status),
        .green (led_green),
        .red   (led_red)
    );
endmodule

// File: rtl/status_led_chk.sv
module status_led_chk (
    input logic clk,
    input logic rst,
    input logic alarm,
    input logic green,
    input logic red,
    input logic valid,
    input logic pwr_high
);
    p_dark_in_reset_r1: assert property (@(posedge clk)
        rst |=> (!green && !red));

    p_one_colour_r2: assert property (@(posedge clk) disable iff (rst)
        !(green && red));

    p_low_is_green_r3: assert property (@(posedge clk) disable iff (rst)
        (valid && !alarm && !pwr_high) |=> (green && !red));

    p_high_is_red_r4: assert property (@(posedge clk) disable iff (rst)
        (valid && !alarm && pwr_high) |=> (red && !green));

    p_blink_starts_green_r6: assert property (@(posedge clk) disable iff (rst)
        (valid && $rose(alarm)) |=> (green && !red));

    p_blink_lit_r6: assert property (@(posedge clk) disable iff (rst)
        (valid && alarm) |=> (green ^ red));
endmodule

bind status_led_drv status_led_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .alarm   (alarm_any),
    .green   (led_green),
    .red     (led_red),
    .valid   (st_valid),
    .pwr_high(st_mode == status_led_pkg::PWR_HIGH)
);

// File: tb/sim_status_led_drv.sv
`timescale 1ns/1ps
module sim_status_led_drv;
    localparam int HALF = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lpm_drive = 1'b1;
    logic lpm_level = 1'b1;
    logic alarm_any = 1'b0;
    logic sel_pin_n = 1'b0;
    logic init_pin = 1'b0;
    logic led_green;
    logic led_red;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string focus = "";

    // reference model state
    int since_rel = 0;
    int n_alarm = 0;
    bit hist[$];
    bit exp_g = 0;
    bit exp_r = 0;
    bit exp_alarm_ctx = 0;
    bit exp_float_ctx = 0;
    bit exp_mode_low = 1;

    always #4 clk = ~clk;

    status_led_drv #(.HALF_CYCLES(HALF)) u0 (
        .clk(clk), .rst(rst), .lpm_drive(lpm_drive), .lpm_level(lpm_level),
        .alarm_any(alarm_any), .sel_pin_n(sel_pin_n), .init_pin(init_pin),
        .led_green(led_green), .led_red(led_red)
    );

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            since_rel = 0;
            n_alarm = 0;
            hist.delete();
            exp_g = 0;
            exp_r = 0;
        end else begin
            since_rel++;
            hist.push_back(lpm_drive ? lpm_level : 1'b1);
            if (since_rel >= 3) begin
                exp_mode_low  = hist[hist.size() - 3];
                exp_alarm_ctx = alarm_any;
                exp_float_ctx = !lpm_drive;
                if (alarm_any) begin
                    exp_r = ((n_alarm / HALF) % 2) == 1;
                    exp_g = !exp_r;
                end else begin
                    exp_g = exp_mode_low;
                    exp_r = !exp_mode_low;
                end
            end else begin
                exp_g = 0;
                exp_r = 0;
            end
            if (alarm_any) n_alarm++;
            else n_alarm = 0;
            while (hist.size() > 3) void'(hist.pop_front());
        end
    end

    always @(negedge clk) begin
        string tag;
        if (cycles > 0) begin
            if (since_rel < 3) tag = "R1";
            else if (exp_alarm_ctx) tag = "R6";
            else if (exp_float_ctx) tag = "R5";
            else if (exp_mode_low) tag = "R3";
            else tag = "R4";
            if (focus != "") tag = {tag, "/", focus};
            total++;
            if (led_green !== exp_g || led_red !== exp_r) begin
                bad++;
                $display("FAIL %s cycle %0d: got g=%b r=%b expected g=%b r=%b",
                         tag, cycles, led_green, led_red, exp_g, exp_r);
            end
            total++;
            if (led_green === 1'b1 && led_red === 1'b1) begin
                bad++;
                $display("FAIL R2 cycle %0d: got g=1 r=1 expected at most one lit",
                         cycles);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset holds the indicator dark
        step(3);
        rst = 1'b0;
        step(12);
        // R3 -> R4: host drives high power
        lpm_level = 1'b0;
        step(10);
        // R5: pin released, pull-up gives low power even with level 0
        lpm_drive = 1'b0;
        step(10);
        lpm_drive = 1'b1;
        step(8);
        // R6: alarm in high power mode, several half-periods
        focus = "R6";
        alarm_any = 1'b1;
        step(4 * HALF + 3);
        // R7: alarm cleared, solid colour returns; short re-alarm restarts green
        focus = "R7";
        alarm_any = 1'b0;
        step(6);
        alarm_any = 1'b1;
        step(3);
        alarm_any = 1'b0;
        step(2);
        alarm_any = 1'b1;
        step(2 * HALF + 1);
        alarm_any = 1'b0;
        step(6);
        // R8: toggling select and init pins in both modes
        focus = "R8";
        for (int i = 0; i < 20; i++) begin
            sel_pin_n = i[0];
            init_pin  = i[1];
            if (i == 10) lpm_level = 1'b1;
            step(1);
        end
        alarm_any = 1'b1;
        for (int i = 0; i < 12; i++) begin
            sel_pin_n = ~sel_pin_n;
            init_pin  = i[2];
            step(1);
        end
        alarm_any = 1'b0;
        step(4);
        // mode changes during alarm, then alarm ends in the new mode
        focus = "R6";
        alarm_any = 1'b1;
        step(3);
        lpm_level = 1'b0;
        step(HALF + 4);
        alarm_any = 1'b0;
        step(5);
        // R1: reset in the middle of an alarm
        focus = "R1";
        alarm_any = 1'b1;
        step(7);
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(3 * HALF);
        alarm_any = 1'b0;
        step(5);
        focus = "";
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule